// File: doc/BRIEF.md
# Branch Shadow Cancel and Interrupt Injection Control

This block sits in the control path of a three-stage pipeline (fetch, decode, execute). When the execute stage carries out a jump or a taken branch, the two younger instructions already in flight must not retire. The block raises a decode-stage cancel flag and an execute-stage cancel flag that follow those two instructions down the pipe. The datapath still lets a cancelled instruction read and combine its operands. It uses the flags to suppress the register write-back and any load or store access of that instruction. A jump or taken branch therefore occupies three pipeline cycles.

Interrupts are entered without a separate trap mechanism. A sampled request makes an interrupt pending. At the first safe fetch, the block drives a select that makes the instruction-register mux take a fixed jump-and-link word instead of the fetched word. That word links into r14 and targets offset 10 from r0. Normally the return-address register follows the address of the instruction in decode. In the cycle after the injected word has been latched, the block withholds that register's clock enable once, so the saved link address is the one of the instruction that was displaced. Priority, vectoring and nesting belong to an external controller and to software.

All state moves only on a pipeline-advance cycle. Two small state machines hold the state. The cancel machine has the states CLEAR (no flags), BOTH (both flags set) and EXONLY (only the execute flag set). Its transitions are CLEAR to BOTH on an effective jump or branch, BOTH to EXONLY on advance, and EXONLY to CLEAR on advance. The interrupt machine has the states IDLE, PEND (request waiting) and INJ (the injected word is in decode). Its transitions are IDLE to PEND on a sampled request, PEND to INJ when the injection is latched, INJ to IDLE on advance, and INJ to PEND on advance when a new request is present.

Top module: `shadow_irq_ctl`

## Requirements
- R1: After reset, both cancel flags are 0 and the injection select is 0, and the return-address enable equals the advance input.
- R2: A jump or taken-branch indication during an advance cycle while the execute cancel flag is 0 makes both cancel flags 1 in the next cycle.
- R3: From the state with both flags set, one advance leaves only the execute flag set, and a further advance clears it. The shadow is two instructions and the whole sequence is three cycles.
- R4: A jump or taken-branch indication while the execute cancel flag is 1 has no effect. Such an instruction is cancelled, and the flags run out as in R3.
- R5: In a cycle without advance, the cancel flags, the pending interrupt and the injection state all hold, whatever the other inputs are.
- R6: A request is sampled only on an advance cycle. From the next cycle on it is pending, and a pending interrupt with no blocker drives the injection select high in that same cycle (combinational).
- R7: The injection select is 0 while the inhibit input is 1, while either cancel flag is 1, while a jump or taken branch takes effect in that cycle, and while the injected word is in decode. A pending interrupt waits through these conditions and is not lost.
- R8: The pending interrupt clears only when the injection select is 1 during an advance cycle. A request present in that same cycle is ignored.
- R9: The return-address enable equals the advance input, except in the cycle in which the injected word is in decode, when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Pipeline advance; all stages move on this cycle |
| ex_jump_i | input | 1 | Execute stage holds a jump |
| ex_br_taken_i | input | 1 | Execute stage holds a branch whose condition holds |
| irq_i | input | 1 | Interrupt request from the external controller |
| irq_hold_i | input | 1 | Decode stage holds a word that must not be split from the next (prefix or branch) |
| dc_annul_o | output | 1 | Decode-stage instruction is cancelled |
| ex_annul_o | output | 1 | Execute-stage instruction is cancelled (suppress write-back and memory access) |
| inj_sel_o | output | 1 | Instruction mux takes the fixed jump-and-link word instead of the fetched word |
| ret_ce_o | output | 1 | Clock enable of the return-address register |

## Verification
Both functions can fall in the same cycle: a jump or taken branch is executing while an interrupt is pending. Injecting then would put the forced word into the shadow, where it would be cancelled and lost. The bench makes a request pending and asserts a jump in the very cycle in which the select would first rise. It checks that the select is 0 in that cycle and stays 0 while the two shadow flags run out. It then checks that the select rises as soon as both flags are clear, and that an injection advance after that clears the pending state.

// File: rtl/shadow_irq_pkg.sv
package shadow_irq_pkg;

    typedef enum logic [1:0] {
        AN_CLEAR  = 2'd0,
        AN_BOTH   = 2'd1,
        AN_EXONLY = 2'd2
    } annul_st_t;

    typedef enum logic [1:0] {
        IQ_IDLE = 2'd0,
        IQ_PEND = 2'd1,
        IQ_INJ  = 2'd2
    } irq_st_t;

endpackage

// File: rtl/shadow_annul_fsm.sv
module shadow_annul_fsm
    import shadow_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic jump_i,
    input  logic br_taken_i,
    output logic dc_annul_o,
    output logic ex_annul_o,
    output logic take_o
);

    annul_st_t state_q, state_d;

    // A redirect only counts when the executing instruction itself is live.
    always_comb begin
        take_o = (jump_i || br_taken_i) && (state_q == AN_CLEAR);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AN_CLEAR:  if (adv_i && take_o) state_d = AN_BOTH;
            AN_BOTH:   if (adv_i)           state_d = AN_EXONLY;
            AN_EXONLY: if (adv_i)           state_d = AN_CLEAR;
            default:                        state_d = AN_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= AN_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        dc_annul_o = 1'b0;
        ex_annul_o = 1'b0;
        unique case (state_q)
            AN_CLEAR:  ;
            AN_BOTH:   begin dc_annul_o = 1'b1; ex_annul_o = 1'b1; end
            AN_EXONLY: ex_annul_o = 1'b1;
            default:   ;
        endcase
    end

    // R2: an effective redirect on advance cancels both younger instructions
    a_r2_take_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && take_o) |=> (dc_annul_o && ex_annul_o));

    // R3: the decode-stage victim moves into execute on the next advance
    a_r3_shadow_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && dc_annul_o) |=> (!dc_annul_o && ex_annul_o));

    // R3: the execute-stage victim leaves on the advance after
    a_r3_shadow_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && ex_annul_o && !dc_annul_o) |=> (!dc_annul_o && !ex_annul_o));

    // R4: a cancelled redirect never starts a new shadow
    a_r4_no_nested_take: assert property (@(posedge clk) disable iff (!rst_n)
        ex_annul_o |-> !take_o);

    // R5: no advance, no movement
    a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(state_q));

endmodule

// File: rtl/shadow_irq_fsm.sv
module shadow_irq_fsm
    import shadow_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic irq_i,
    input  logic hold_i,
    input  logic blocked_i,
    output logic inj_sel_o,
    output logic ret_ce_o
);

    irq_st_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IQ_IDLE: if (adv_i && irq_i)     state_d = IQ_PEND;
            IQ_PEND: if (adv_i && inj_sel_o) state_d = IQ_INJ;
            IQ_INJ:  if (adv_i)              state_d = irq_i ? IQ_PEND : IQ_IDLE;
            default:                         state_d = IQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        inj_sel_o = 1'b0;
        ret_ce_o  = adv_i;
        unique case (state_q)
            IQ_IDLE: ;
            IQ_PEND: inj_sel_o = !hold_i && !blocked_i;
            IQ_INJ:  ret_ce_o  = 1'b0;
            default: ;
        endcase
    end

    // R8: a latched injection retires the pending request
    a_r8_inject_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && inj_sel_o) |=> !inj_sel_o);

    // R9: the return address is frozen for exactly the cycle after injection
    a_r9_ret_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && inj_sel_o) |=> !ret_ce_o);

    // R6: a request sampled on advance becomes pending, not injected at once
    a_r6_sample_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IQ_IDLE) |-> !inj_sel_o);

    // R5: no advance, no movement
    a_r5_irq_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(state_q));

endmodule

// File: rtl/shadow_irq_ctl.sv
module shadow_irq_ctl
    import shadow_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic ex_jump_i,
    input  logic ex_br_taken_i,
    input  logic irq_i,
    input  logic irq_hold_i,
    output logic dc_annul_o,
    output logic ex_annul_o,
    output logic inj_sel_o,
    output logic ret_ce_o
);

    logic take;
    logic inj_blocked;

    shadow_annul_fsm u_annul (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv_i),
        .jump_i     (ex_jump_i),
        .br_taken_i (ex_br_taken_i),
        .dc_annul_o (dc_annul_o),
        .ex_annul_o (ex_annul_o),
        .take_o     (take)
    );

    // Injecting into a shadow would lose the interrupt, so wait it out.
    assign inj_blocked = take || dc_annul_o || ex_annul_o;

    shadow_irq_fsm u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_i     (adv_i),
        .irq_i     (irq_i),
        .hold_i    (irq_hold_i),
        .blocked_i (inj_blocked),
        .inj_sel_o (inj_sel_o),
        .ret_ce_o  (ret_ce_o)
    );

    // R7: the forced word never lands where it would be cancelled
    a_r7_no_inject_in_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        inj_sel_o |-> (!dc_annul_o && !ex_annul_o && !irq_hold_i));

    // R7: an injection is never immediately cancelled by a redirect
    a_r7_inject_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && inj_sel_o) |=> !dc_annul_o);

    // R1: quiet outputs in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!dc_annul_o && !ex_annul_o && !inj_sel_o));

endmodule

// File: tb/test_shadow_irq_ctl.sv
module test_shadow_irq_ctl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv = 1'b0, jmp = 1'b0, brt = 1'b0, irq = 1'b0, hold = 1'b0;
    logic dc_an, ex_an, inj, ret_ce;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shadow_irq_ctl i_shadow_irq_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .adv_i         (adv),
        .ex_jump_i     (jmp),
        .ex_br_taken_i (brt),
        .irq_i         (irq),
        .irq_hold_i    (hold),
        .dc_annul_o    (dc_an),
        .ex_annul_o    (ex_an),
        .inj_sel_o     (inj),
        .ret_ce_o      (ret_ce)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Drive one cycle's inputs at the falling edge; outputs settle before the rising edge.
    task automatic cyc(logic a, logic j, logic b, logic q, logic h);
        @(negedge clk);
        adv = a; jmp = j; brt = b; irq = q; hold = h;
        #1;
    endtask

    task automatic flags(string req, logic d, logic e);
        chk(req, "dc_annul", dc_an, d);
        chk(req, "ex_annul", ex_an, e);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        rst_n = 1'b1;
        cyc(1, 0, 0, 0, 0);
        flags("R1", 0, 0);
        chk("R1", "inj_sel", inj, 0);
        chk("R1", "ret_ce", ret_ce, 1);
        cyc(0, 0, 0, 0, 0);
        chk("R1", "ret_ce follows adv", ret_ce, 0);
    endtask

    task automatic t_jump();
        cyc(1, 1, 0, 0, 0);
        flags("R2", 0, 0);
        cyc(1, 0, 0, 0, 0);
        flags("R2", 1, 1);
        cyc(1, 0, 0, 0, 0);
        flags("R3", 0, 1);
        cyc(1, 0, 0, 0, 0);
        flags("R3", 0, 0);
    endtask

    task automatic t_branch_stall();
        cyc(1, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0);
        flags("R2", 1, 1);
        cyc(0, 1, 1, 1, 0);
        flags("R5", 1, 1);
        cyc(1, 0, 0, 0, 0);
        flags("R5", 1, 1);
        chk("R5", "irq ignored without adv", inj, 0);
        cyc(0, 0, 0, 0, 0);
        flags("R3", 0, 1);
        cyc(1, 0, 0, 0, 0);
        flags("R5", 0, 1);
        cyc(1, 0, 0, 0, 0);
        flags("R3", 0, 0);
        chk("R6", "no stalled irq pending", inj, 0);
    endtask

    task automatic t_shadow_jump();
        cyc(1, 1, 0, 0, 0);
        cyc(1, 1, 0, 0, 0);
        flags("R4", 1, 1);
        cyc(1, 0, 1, 0, 0);
        flags("R4", 0, 1);
        cyc(1, 0, 0, 0, 0);
        flags("R4", 0, 0);
    endtask

    task automatic t_irq_basic();
        cyc(1, 0, 0, 1, 0);
        chk("R6", "not yet pending", inj, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R6", "pending drives select", inj, 1);
        cyc(0, 0, 0, 0, 0);
        chk("R8", "holds over stall", inj, 1);
        cyc(1, 0, 0, 1, 0);
        chk("R9", "ret_ce at injection", ret_ce, 1);
        cyc(1, 0, 0, 0, 0);
        chk("R8", "cleared after latch", inj, 0);
        chk("R9", "ret_ce frozen", ret_ce, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R9", "ret_ce back", ret_ce, 1);
        chk("R8", "same-cycle irq ignored", inj, 0);
    endtask

    task automatic t_irq_inhibit();
        cyc(1, 0, 0, 1, 0);
        cyc(1, 0, 0, 0, 1);
        chk("R7", "inhibit blocks", inj, 0);
        cyc(1, 0, 0, 0, 1);
        chk("R7", "inhibit still blocks", inj, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R7", "released after inhibit", inj, 1);
        cyc(1, 0, 0, 0, 0);
        chk("R9", "ret_ce frozen", ret_ce, 0);
        chk("R8", "cleared", inj, 0);
    endtask

    task automatic t_irq_vs_jump();
        cyc(1, 0, 0, 1, 0);
        cyc(1, 1, 0, 0, 0);
        chk("R7", "jump in same cycle blocks", inj, 0);
        cyc(1, 0, 0, 0, 0);
        flags("R7", 1, 1);
        chk("R7", "blocked in shadow", inj, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R7", "blocked by ex flag", inj, 0);
        cyc(1, 0, 0, 0, 0);
        flags("R7", 0, 0);
        chk("R7", "not lost", inj, 1);
        cyc(1, 0, 0, 0, 0);
        chk("R9", "ret_ce frozen", ret_ce, 0);
        chk("R8", "cleared", inj, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R9", "ret_ce back", ret_ce, 1);
    endtask

    task automatic t_irq_during_inj();
        cyc(1, 0, 0, 1, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R6", "pending", inj, 1);
        cyc(1, 0, 0, 1, 0);
        chk("R7", "blocked while injected word in decode", inj, 0);
        chk("R9", "ret_ce frozen", ret_ce, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R6", "new request pending", inj, 1);
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R8", "cleared", inj, 0);
    endtask

    initial begin
        t_reset();
        t_jump();
        t_branch_stall();
        t_shadow_jump();
        t_irq_basic();
        t_irq_inhibit();
        t_irq_vs_jump();
        t_irq_during_inj();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule